// File: doc/BRIEF.md
# Configurable-Sense Interrupt Controller

This block merges up to 32 interrupt sources into one request line toward a processor. Each source is configured on its own as level-sensitive or edge-sensitive, and as active-high/rising or active-low/falling. Edge-sensitive sources latch into a sticky pending bit that software clears by writing ones to an acknowledge register. Level-sensitive sources show their qualified input level directly as pending. A per-source enable mask selects which pending bits can raise the request, and a global gate holds the request low when cleared.

The request leaves the block through a register, either as a level that stays high while any enabled source is pending, or as a single-cycle pulse when that condition first becomes true. The pulse form lets a second controller take this block's request as one of its edge-sensitive inputs. A small word-addressed read/write port, with combinational read data, exposes the configuration, the pending vector and a priority register that reports the lowest-numbered enabled pending source. All inputs are assumed synchronous to the block clock.

Top module: `irq_ctrl_top`

Register addresses (3-bit `reg_addr`): 0 pending status (read-only), 1 acknowledge (write-only, reads 0), 2 enable mask, 3 sense select (1 = edge, 0 = level), 4 polarity (1 = active-high/rising, 0 = active-low/falling), 5 control (bit 0 global gate, bit 1 pulse output), 6 priority (read-only: bit 31 valid, bits 4:0 source index).

## Requirements
- R1: After synchronous reset the enable mask, sense select, control register and priority register read 0, polarity reads all ones, and `irq_req` is 0.
- R2: A source in level mode reads as pending (status address 0) exactly when its input equals its polarity bit, with no clock delay through the status read.
- R3: A source in edge mode sets its pending bit on the clock after its input makes the selected transition (0-to-1 for polarity 1, 1-to-0 for polarity 0), and the bit stays set after the input returns; the opposite transition sets nothing.
- R4: Writing the acknowledge address clears the edge-mode pending bits at the positions written as 1 and leaves the others; if a new edge arrives in the same cycle as its acknowledge, the bit stays set.
- R5: An acknowledge write has no effect on a level-mode pending bit.
- R6: Only pending sources whose enable bit (address 2) is 1 can raise `irq_req`.
- R7: With control bit 0 cleared, `irq_req` is 0 from the next cycle on, whatever is pending.
- R8: In level output mode (control bit 1 = 0), `irq_req` goes high one clock after an enabled pending source appears with the gate set, and stays high while that holds.
- R9: In pulse output mode (control bit 1 = 1), `irq_req` is high for exactly one cycle each time the gated request rises from 0 to 1, and further sources becoming pending while it is already high give no new pulse.
- R10: The priority register reports in bits 4:0 the lowest-numbered source that is both pending and enabled, with bit 31 set; with none, it reads 0. It does not depend on the global gate.
- R11: The enable, sense select and polarity registers read back what was written, and the control register reads back only its two defined bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | N_IRQ | Interrupt source inputs, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| irq_req | output | 1 | Registered request toward the processor |

## Verification
The bench goes after the acknowledge racing a fresh edge on the same bit; a design that let the clear win would silently lose that interrupt. It checks that an acknowledge aimed at a level source leaves it pending and that a transition of the unselected direction sets nothing, which a design with a shared or inverted edge detector would get wrong. In pulse mode it counts pulses while a second source arrives during an active request, where a design that pulsed per source instead of per rise of the combined request would emit an extra pulse. It also checks the one-cycle latency of the level output and that the priority index skips a pending but masked lower source.

// File: rtl/irq_ctrl_pkg.sv
// Shared definitions for the interrupt controller: register addresses
// and control-register bit positions.
package irq_ctrl_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 3'd0,
        REG_ACK    = 3'd1,
        REG_ENABLE = 3'd2,
        REG_SENSE  = 3'd3,
        REG_POL    = 3'd4,
        REG_CTRL   = 3'd5,
        REG_PRIO   = 3'd6
    } reg_addr_e;

    localparam int CTRL_GATE_BIT  = 0;
    localparam int CTRL_PULSE_BIT = 1;

endpackage

// File: rtl/irq_sense_cell.sv
// One interrupt source: qualifies the raw input by polarity, detects
// the selected edge against the previous sample, and holds a sticky
// edge flag that an acknowledge clears. Assumes irq_raw is synchronous.
module irq_sense_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic edge_sel,
    input  logic pol_high,
    input  logic ack,
    output logic pend
);

    logic prev_q;
    logic edge_q;
    logic hit_level;
    logic hit_edge;

    // Previous input sample; loaded during reset too so release sees no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= irq_raw;
        end else begin
            prev_q <= irq_raw;
        end
    end

    // Qualified level and selected transition.
    always_comb begin
        hit_level = pol_high ? irq_raw : ~irq_raw;
        hit_edge  = pol_high ? (irq_raw & ~prev_q) : (~irq_raw & prev_q);
    end

    // Sticky edge flag: a new edge wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
        end else if (!edge_sel) begin
            edge_q <= 1'b0;
        end else begin
            edge_q <= hit_edge | (edge_q & ~ack);
        end
    end

    // Pending view depends on the selected sense.
    assign pend = edge_sel ? edge_q : hit_level;

endmodule

// File: rtl/irq_prio_enc.sv
// Finds the lowest-numbered set bit of a request vector and reports its
// index with a valid flag. Purely combinational.
module irq_prio_enc #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
        valid = |req;
    end

endmodule

// File: rtl/irq_out_gen.sv
// Forms the registered request line from the gated request, either as a
// level or as a one-cycle pulse on each 0-to-1 change of the gated request.
module irq_out_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic pulse_mode,
    input  logic any_active,
    output logic irq_req
);

    logic gated;
    logic gated_q;
    logic req_q;

    assign gated = gate_en & any_active;

    // Previous gated request, used to find its rising change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gated_q <= 1'b0;
        end else begin
            gated_q <= gated;
        end
    end

    // Output register selecting level or pulse form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (pulse_mode) begin
            req_q <= gated & ~gated_q;
        end else begin
            req_q <= gated;
        end
    end

    assign irq_req = req_q;

endmodule

// File: rtl/irq_ctrl_top.sv
// Interrupt controller top: configuration registers, per-source sense
// cells, priority encoder and output former behind a word-addressed
// register port. Assumes N_IRQ <= DW and sources synchronous to clk.
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int N_IRQ = 32,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_src,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_req
);

    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic [N_IRQ-1:0] enable_q;
    logic [N_IRQ-1:0] sense_q;
    logic [N_IRQ-1:0] pol_q;
    logic             gate_q;
    logic             pulse_q;
    logic [N_IRQ-1:0] ack_vec;
    logic [N_IRQ-1:0] pend_vec;
    logic [N_IRQ-1:0] active_vec;
    logic             prio_valid;
    logic [IDX_W-1:0] prio_idx;
    reg_addr_e        addr_e;

    assign addr_e = reg_addr_e'(reg_addr);

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            sense_q  <= '0;
            pol_q    <= '1;
            gate_q   <= 1'b0;
            pulse_q  <= 1'b0;
        end else if (reg_wr) begin
            case (addr_e)
                REG_ENABLE: enable_q <= reg_wdata[N_IRQ-1:0];
                REG_SENSE:  sense_q  <= reg_wdata[N_IRQ-1:0];
                REG_POL:    pol_q    <= reg_wdata[N_IRQ-1:0];
                REG_CTRL: begin
                    gate_q  <= reg_wdata[CTRL_GATE_BIT];
                    pulse_q <= reg_wdata[CTRL_PULSE_BIT];
                end
                default: ;
            endcase
        end
    end

    // Acknowledge strobe vector for this cycle.
    assign ack_vec = (reg_wr && addr_e == REG_ACK) ? reg_wdata[N_IRQ-1:0] : '0;

    // One sense cell per source.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
        irq_sense_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_raw  (irq_src[g]),
            .edge_sel (sense_q[g]),
            .pol_high (pol_q[g]),
            .ack      (ack_vec[g]),
            .pend     (pend_vec[g])
        );
    end

    assign active_vec = pend_vec & enable_q;

    irq_prio_enc #(
        .N  (N_IRQ),
        .IW (IDX_W)
    ) u_prio (
        .req   (active_vec),
        .valid (prio_valid),
        .idx   (prio_idx)
    );

    irq_out_gen u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_en    (gate_q),
        .pulse_mode (pulse_q),
        .any_active (|active_vec),
        .irq_req    (irq_req)
    );

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (addr_e)
            REG_STATUS: reg_rdata[N_IRQ-1:0] = pend_vec;
            REG_ENABLE: reg_rdata[N_IRQ-1:0] = enable_q;
            REG_SENSE:  reg_rdata[N_IRQ-1:0] = sense_q;
            REG_POL:    reg_rdata[N_IRQ-1:0] = pol_q;
            REG_CTRL: begin
                reg_rdata[CTRL_GATE_BIT]  = gate_q;
                reg_rdata[CTRL_PULSE_BIT] = pulse_q;
            end
            REG_PRIO: begin
                reg_rdata[DW-1]      = prio_valid;
                reg_rdata[IDX_W-1:0] = prio_idx;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctrl_checker.sv
// Property checker for irq_ctrl_top, attached by bind below.
module irq_ctrl_checker #(
    parameter int N  = 32,
    parameter int DW = 32,
    parameter int IW = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq_req,
    input logic         gate,
    input logic         pulse_mode,
    input logic [N-1:0] sense,
    input logic [N-1:0] pend,
    input logic [N-1:0] ack,
    input logic [N-1:0] active,
    input logic         prio_valid,
    input logic [IW-1:0] prio_idx
);

    initial begin
        a_width_fits: assert (N <= DW && N >= 1);
    end

    // R7: a cleared gate forces the request low on the next cycle
    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !irq_req);

    // R8: level output follows a gated active request one cycle later
    p_level_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && gate && (|active)) |=> irq_req);

    // R9: a pulse never lasts two cycles while pulse mode holds
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && irq_req) |=> !(pulse_mode && irq_req));

    // R3: an unacknowledged edge flag stays set while edge mode holds
    p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend & sense & ~ack) & sense & ~pend) == '0));

    // R10: reported index is active and no lower source is active
    p_prio_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prio_valid |-> (active[prio_idx] &&
                        ((active & ((N'(1) << prio_idx) - N'(1))) == '0)));

    // R10: any active source yields a valid priority report
    p_prio_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|active) |-> prio_valid);

endmodule

bind irq_ctrl_top irq_ctrl_checker #(
    .N  (N_IRQ),
    .DW (DW),
    .IW (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .gate       (gate_q),
    .pulse_mode (pulse_q),
    .sense      (sense_q),
    .pend       (pend_vec),
    .ack        (ack_vec),
    .active     (active_vec),
    .prio_valid (prio_valid),
    .prio_idx   (prio_idx)
);

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;

    localparam int N  = 32;
    localparam int DW = 32;
    localparam logic [2:0] A_STATUS = 3'd0, A_ACK = 3'd1, A_ENABLE = 3'd2,
                           A_SENSE = 3'd3, A_POL = 3'd4, A_CTRL = 3'd5, A_PRIO = 3'd6;

    // Level-mode table: {polarity, inputs, expected status} (R2)
    localparam int NVEC = 6;
    localparam logic [95:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
        {32'h0000_0000, 32'h1234_5678, 32'hEDCB_A987},
        {32'hFFFF_0000, 32'h00FF_00FF, 32'h00FF_FF00},
        {32'h0F0F_0F0F, 32'h0000_FFFF, 32'hF0F0_0F0F}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl_top #(.N_IRQ(N), .DW(DW)) i_irq_ctrl_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_in(input logic [31:0] v);
        @(negedge clk);
        irq_src = v;
    endtask

    task automatic count_pulses(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            if (irq_req) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int np;

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 irq_req in reset", {31'd0, irq_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_ENABLE, d); check("R1 enable", d, 32'h0);
        rd(A_SENSE, d);  check("R1 sense", d, 32'h0);
        rd(A_POL, d);    check("R1 polarity", d, 32'hFFFF_FFFF);
        rd(A_CTRL, d);   check("R1 control", d, 32'h0);
        rd(A_PRIO, d);   check("R1 priority", d, 32'h0);
        check("R1 irq_req after reset", {31'd0, irq_req}, 32'd0);

        // R11: readback
        wr(A_ENABLE, 32'hA5A5_0F0F); rd(A_ENABLE, d); check("R11 enable", d, 32'hA5A5_0F0F);
        wr(A_SENSE, 32'h3C3C_1234);  rd(A_SENSE, d);  check("R11 sense", d, 32'h3C3C_1234);
        wr(A_CTRL, 32'hFFFF_FFFC);   rd(A_CTRL, d);   check("R11 control", d, 32'h0);
        wr(A_ENABLE, 32'h0);
        wr(A_SENSE, 32'h0);

        // R2: table walk in level mode
        for (int v = 0; v < NVEC; v++) begin
            wr(A_POL, VEC[v][95:64]);
            set_in(VEC[v][63:32]);
            rd(A_STATUS, d);
            check($sformatf("R2 vector %0d", v), d, VEC[v][31:0]);
        end
        rd(A_POL, d); check("R11 polarity", d, 32'h0F0F_0F0F);

        // R3: edge capture, bits 7:0 rising, others falling
        wr(A_POL, 32'h0000_00FF);
        set_in(32'h0);
        wr(A_SENSE, 32'hFFFF_FFFF);
        set_in(32'h0000_0003);
        set_in(32'h0000_0000);
        @(negedge clk);
        rd(A_STATUS, d); check("R3 rising sticky, falling ignored", d, 32'h0000_0003);
        set_in(32'h0000_0100);
        @(negedge clk);
        rd(A_STATUS, d); check("R3 rising ignored on falling bit", d, 32'h0000_0003);
        set_in(32'h0000_0000);
        @(negedge clk);
        rd(A_STATUS, d); check("R3 falling edge", d, 32'h0000_0103);

        // R4: acknowledge
        wr(A_ACK, 32'h0000_0001);
        rd(A_STATUS, d); check("R4 ack clears only written bit", d, 32'h0000_0102);
        @(negedge clk);
        irq_src = 32'h0000_0004;
        reg_wr = 1'b1; reg_addr = A_ACK; reg_wdata = 32'h0000_0004;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(A_STATUS, d); check("R4 edge wins over same-cycle ack", d, 32'h0000_0106);
        set_in(32'h0);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd(A_STATUS, d); check("R4 ack all", d, 32'h0);

        // R5: ack has no effect on a level source (bit 4, active high)
        wr(A_SENSE, 32'hFFFF_FFEF);
        set_in(32'h0000_0010);
        wr(A_ACK, 32'h0000_0010);
        rd(A_STATUS, d); check("R5 level bit survives ack", d, 32'h0000_0010);

        // R6: mask
        wr(A_CTRL, 32'h1);
        wr(A_ENABLE, 32'hFFFF_FFEF);
        @(negedge clk);
        check("R6 masked source gives no request", {31'd0, irq_req}, 32'd0);

        // R8: level output latency
        wr(A_ENABLE, 32'h0000_0010);
        check("R8 not yet high", {31'd0, irq_req}, 32'd0);
        @(negedge clk);
        check("R8 high one cycle later", {31'd0, irq_req}, 32'd1);
        repeat (3) @(negedge clk);
        check("R8 stays high", {31'd0, irq_req}, 32'd1);

        // R7: gate off
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        check("R7 gate cleared", {31'd0, irq_req}, 32'd0);
        repeat (3) @(negedge clk);
        check("R7 stays low", {31'd0, irq_req}, 32'd0);

        // R9: pulse mode
        wr(A_CTRL, 32'h3);
        count_pulses(8, np);
        check("R9 one pulse on rise", np, 32'd1);
        wr(A_ENABLE, 32'h0000_0011);
        set_in(32'h0000_0011);
        count_pulses(6, np);
        check("R9 no pulse while already requesting", np, 32'd0);
        set_in(32'h0000_0010);
        wr(A_ACK, 32'h0000_0001);
        set_in(32'h0000_0000);
        repeat (3) @(negedge clk);
        irq_src = 32'h0000_0010;
        count_pulses(6, np);
        check("R9 new pulse after fall and rise", np, 32'd1);

        // R10: priority
        wr(A_CTRL, 32'h0);
        set_in(32'h0010_0010);
        set_in(32'h0000_0010);
        set_in(32'h8000_0010);
        set_in(32'h0000_0010);
        @(negedge clk);
        wr(A_ENABLE, 32'hFFFF_FFFF);
        rd(A_PRIO, d); check("R10 lowest pending", d, 32'h8000_0004);
        wr(A_ENABLE, 32'hFFFF_FFEF);
        rd(A_PRIO, d); check("R10 skips masked lower", d, 32'h8000_0014);
        wr(A_ENABLE, 32'h8000_0000);
        rd(A_PRIO, d); check("R10 top index", d, 32'h8000_001F);
        wr(A_ENABLE, 32'h0);
        rd(A_PRIO, d); check("R10 none", d, 32'h0);

        finish_run();
    end

endmodule